// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block turns a set of supply rails on and off in a fixed order. It drives one enable per rail and reads back one power-good per rail. On a start request it brings the rails up in index order. Each enable waits for the previous rail's power-good and then for a fixed stagger interval, which limits inrush. When the request is withdrawn, the rails go down in reverse order with the same spacing. A rail marked as standby is always enabled and is never turned off.

The block supervises the rails while it runs. A rail that does not report power-good within a timeout is a fault. So is an external protection fault on an enabled rail, and so is a power-good drop on a rail that has already come up. A rail in a global group shuts down every non-standby rail when it faults. The block then waits out a cooldown and restarts the whole sequence. It allows only a bounded number of restarts, and after that it latches off until the host clears it. The retry count returns to zero once the system has run fault-free for a qualification interval. A rail in a local group that faults while the system is up is switched off on its own, and the other rails keep running.

A power-fail warning drops the early-off rails at once and raises a flag to the host. The remaining rails then go down in reverse order, so core rails leave last. The block does not restart while the warning is active.

Top module: `psq_seq`

## Requirements
- R1: Every rail in STBY_MASK (default rail 0) has its enable high at all times after reset.
- R2: On start_i, rails are enabled in ascending index order. The enable of rail k rises STAGGER_CYC+1 cycles after the cycle in which power-good of rail k-1 is first driven high. Rail 1 rises 2*STAGGER_CYC+2 cycles after start_i is first driven high, because standby rail 0 is already good.
- R3: If an enabled rail's power-good stays low for PG_TMO_CYC cycles, a fault is raised in the cycle its enable went high plus PG_TMO_CYC. The fault has kind 1 (timeout).
- R4: A fault on a global-group rail drops all non-standby enables in the same cycle. After COOL_CYC cycles the full sequence restarts, so rail 1 is re-enabled COOL_CYC+2*STAGGER_CYC+1 cycles after the drop. The fault status holds the rail index, the kind and the retry number. That status stays valid until clr_i.
- R5: The fault that would be retry number RETRY_MAX+1 instead latches the block. In that state latched_o is high, the status reports retry RETRY_MAX+1, and all non-standby enables stay low. The block leaves that state only on clr_i.
- R6: An external fault on an enabled rail (kind 3) is a fault event. So is a power-good drop on a rail that is already up (kind 2). When both occur, the lowest rail index is reported.
- R7: A fault on a rail in LOCAL_MASK (default rail 2) while the system is up disables only that rail. up_o and all other enables are unchanged.
- R8: When start_i falls while the system is up, enables are released in descending index order. The first release comes STAGGER_CYC+1 cycles after start_i falls, and each later release follows STAGGER_CYC cycles after the previous one.
- R9: When pfail_i is sampled high, every rail in EARLY_MASK (default rail 3) is disabled on that edge, and pfail_o is set. The other non-standby rails then go down in descending order, STAGGER_CYC apart. No restart happens while pfail_i is high. pfail_o clears on clr_i.
- R10: The retry count returns to zero after QUAL_CYC fault-free cycles in the up state. Without such an interval, consecutive faults report retry numbers that increase by one each time.
- R11: After reset only the standby enables are high, and up_o, latched_o, pfail_o and fault_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Level request: high powers up, low powers down |
| pfail_i | input | 1 | Early power-fail warning |
| clr_i | input | 1 | Host clear for fault status, power-fail flag and latch |
| pg_i | input | N_RAILS | Power-good per rail |
| ext_fault_i | input | N_RAILS | External protection fault per rail |
| en_o | output | N_RAILS | Enable per rail |
| up_o | output | 1 | All rails sequenced and running |
| latched_o | output | 1 | Latched fault, retries exhausted |
| pfail_o | output | 1 | Power-fail seen, for the host |
| fault_valid_o | output | 1 | Fault status holds a record |
| fault_rail_o | output | $clog2(N_RAILS) | Index of the last faulting rail |
| fault_kind_o | output | 2 | 1 timeout, 2 power-good drop, 3 external |
| fault_retry_o | output | $clog2(RETRY_MAX+2) | Retry number of the last global fault |

## Verification
The assertions check three rules on every cycle. An enable rises only when the previous rail's power-good was high on that edge. A sampled power-fail leaves no early-off rail enabled on the next cycle. A latched block has no non-standby rail enabled and always reports the exhausted retry number. The bench scenarios are the only way to show the exact cycle spacing of stagger, timeout, cooldown and reverse shutdown. They also cover the local-versus-global containment and the retry counter returning to zero after a qualified run. Both depend on sequences that span many cycles.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_PGW, S_UP, S_DOWN, S_COOL, S_LATCH
  } psq_state_e;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_TMO  = 2'd1,
    FK_DROP = 2'd2,
    FK_EXT  = 2'd3
  } psq_fkind_e;
endpackage

// File: rtl/psq_fault_mon.sv
module psq_fault_mon
  import psq_pkg::*;
#(
  parameter int N_RAILS = 4,
  localparam int IDXW = $clog2(N_RAILS)
) (
  input  logic               arm_i,
  input  logic [N_RAILS-1:0] en_i,
  input  logic [N_RAILS-1:0] up_i,
  input  logic [N_RAILS-1:0] pg_i,
  input  logic [N_RAILS-1:0] ext_i,
  output logic               hit_o,
  output logic [IDXW-1:0]    rail_o,
  output psq_fkind_e         kind_o
);
  // descending scan: lowest faulting index wins
  always_comb begin
    hit_o  = 1'b0;
    rail_o = '0;
    kind_o = FK_NONE;
    for (int k = N_RAILS-1; k >= 0; k--) begin
      if (arm_i && en_i[k] && (ext_i[k] || (up_i[k] && !pg_i[k]))) begin
        hit_o  = 1'b1;
        rail_o = IDXW'(k);
        kind_o = ext_i[k] ? FK_EXT : FK_DROP;
      end
    end
  end
endmodule

// File: rtl/psq_retry.sv
module psq_retry #(
  parameter int RETRY_MAX = 2,
  parameter int QUAL_CYC  = 24,
  localparam int CNTW = $clog2(RETRY_MAX+2),
  localparam int QW   = $clog2(QUAL_CYC+1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bump_i,
  input  logic            clr_i,
  input  logic            qual_i,
  output logic [CNTW-1:0] cnt_o,
  output logic            last_o
);
  logic [QW-1:0] qcnt;
  logic          qual_done;

  assign qual_done = qual_i && (qcnt == QW'(QUAL_CYC-1));
  assign last_o    = (cnt_o == CNTW'(RETRY_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qcnt <= '0;
    end else if (!qual_i) begin
      qcnt <= '0;
    end else if (!qual_done) begin
      qcnt <= qcnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (bump_i) begin
      cnt_o <= last_o ? CNTW'(RETRY_MAX+1) : cnt_o + 1'b1;
    end else if (qual_done) begin
      cnt_o <= '0;
    end
  end
endmodule

// File: rtl/psq_seq.sv
module psq_seq
  import psq_pkg::*;
#(
  parameter int N_RAILS     = 4,
  parameter int STAGGER_CYC = 4,
  parameter int PG_TMO_CYC  = 16,
  parameter int COOL_CYC    = 32,
  parameter int RETRY_MAX   = 2,
  parameter int QUAL_CYC    = 24,
  parameter logic [N_RAILS-1:0] STBY_MASK  = 4'b0001,
  parameter logic [N_RAILS-1:0] EARLY_MASK = 4'b1000,
  parameter logic [N_RAILS-1:0] LOCAL_MASK = 4'b0100,
  localparam int IDXW = $clog2(N_RAILS),
  localparam int CNTW = $clog2(RETRY_MAX+2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               pfail_i,
  input  logic               clr_i,
  input  logic [N_RAILS-1:0] pg_i,
  input  logic [N_RAILS-1:0] ext_fault_i,
  output logic [N_RAILS-1:0] en_o,
  output logic               up_o,
  output logic               latched_o,
  output logic               pfail_o,
  output logic               fault_valid_o,
  output logic [IDXW-1:0]    fault_rail_o,
  output logic [1:0]         fault_kind_o,
  output logic [CNTW-1:0]    fault_retry_o
);
  localparam int TM1  = (STAGGER_CYC > PG_TMO_CYC) ? STAGGER_CYC : PG_TMO_CYC;
  localparam int TMAX = (TM1 > COOL_CYC) ? TM1 : COOL_CYC;
  localparam int TW   = $clog2(TMAX+1);

  psq_state_e         st;
  logic [IDXW-1:0]    idx;
  logic [TW-1:0]      tmr;
  logic [N_RAILS-1:0] en_r, up_r, idx_oh, dn_en;
  psq_fkind_e         fkind;

  logic               mon_hit, mon_arm;
  logic [IDXW-1:0]    mon_rail;
  psq_fkind_e         mon_kind;
  logic               ev, ev_local, bump, rt_last;
  logic [IDXW-1:0]    ev_rail;
  psq_fkind_e         ev_kind;
  logic [CNTW-1:0]    rt_cnt;
  logic               stag_end;

  assign en_o         = en_r | STBY_MASK;
  assign up_o         = (st == S_UP);
  assign latched_o    = (st == S_LATCH);
  assign fault_kind_o = fkind;
  assign idx_oh       = N_RAILS'(1) << idx;
  assign stag_end     = (tmr == TW'(STAGGER_CYC-1));
  assign mon_arm      = (st == S_GAP) || (st == S_PGW) || (st == S_UP);

  psq_fault_mon #(.N_RAILS(N_RAILS)) u_mon (
    .arm_i (mon_arm),
    .en_i  (en_o),
    .up_i  (up_r),
    .pg_i  (pg_i),
    .ext_i (ext_fault_i),
    .hit_o (mon_hit),
    .rail_o(mon_rail),
    .kind_o(mon_kind)
  );

  // priority: power-fail, rail monitor, power-good timeout
  always_comb begin
    ev      = 1'b0;
    ev_rail = mon_rail;
    ev_kind = mon_kind;
    if (!pfail_i) begin
      if (mon_hit) begin
        ev = 1'b1;
      end else if (st == S_PGW && !pg_i[idx] && tmr == TW'(PG_TMO_CYC-1)) begin
        ev      = 1'b1;
        ev_rail = idx;
        ev_kind = FK_TMO;
      end
    end
  end

  assign ev_local = ev && (st == S_UP) && LOCAL_MASK[ev_rail];
  assign bump     = ev && !ev_local;
  assign dn_en    = en_r & ~(pfail_i ? EARLY_MASK : '0) & ~(stag_end ? idx_oh : '0);

  psq_retry #(.RETRY_MAX(RETRY_MAX), .QUAL_CYC(QUAL_CYC)) u_retry (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bump_i(bump),
    .clr_i (latched_o && clr_i),
    .qual_i(up_o),
    .cnt_o (rt_cnt),
    .last_o(rt_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st            <= S_IDLE;
      idx           <= '0;
      tmr           <= '0;
      en_r          <= '0;
      up_r          <= '0;
      pfail_o       <= 1'b0;
      fault_valid_o <= 1'b0;
      fault_rail_o  <= '0;
      fkind         <= FK_NONE;
      fault_retry_o <= '0;
    end else begin
      if (clr_i) begin
        fault_valid_o <= 1'b0;
        pfail_o       <= 1'b0;
      end
      unique case (st)
        S_IDLE: begin
          en_r <= '0;
          up_r <= '0;
          if (start_i && !pfail_i) begin
            st  <= S_GAP;
            idx <= '0;
            tmr <= '0;
          end
        end
        S_GAP, S_PGW, S_UP: begin
          if (pfail_i) begin
            en_r    <= en_r & ~EARLY_MASK;
            up_r    <= up_r & ~EARLY_MASK;
            pfail_o <= 1'b1;
            st      <= S_DOWN;
            idx     <= IDXW'(N_RAILS-1);
            tmr     <= '0;
          end else if (ev) begin
            fault_valid_o <= 1'b1;
            fault_rail_o  <= ev_rail;
            fkind         <= ev_kind;
            if (ev_local) begin
              en_r[ev_rail] <= 1'b0;
              up_r[ev_rail] <= 1'b0;
            end else begin
              fault_retry_o <= rt_cnt + 1'b1;
              en_r <= '0;
              up_r <= '0;
              st   <= rt_last ? S_LATCH : S_COOL;
              tmr  <= '0;
            end
          end else if (st == S_GAP) begin
            if (stag_end) begin
              en_r[idx] <= 1'b1;
              tmr       <= '0;
              st        <= S_PGW;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end else if (st == S_PGW) begin
            if (pg_i[idx]) begin
              up_r[idx] <= 1'b1;
              tmr       <= '0;
              if (idx == IDXW'(N_RAILS-1)) begin
                st <= S_UP;
              end else begin
                idx <= idx + 1'b1;
                st  <= S_GAP;
              end
            end else begin
              tmr <= tmr + 1'b1;
            end
          end else if (!start_i) begin
            st  <= S_DOWN;
            idx <= IDXW'(N_RAILS-1);
            tmr <= '0;
          end
        end
        S_DOWN: begin
          en_r <= dn_en;
          up_r <= up_r & dn_en;
          if (pfail_i) pfail_o <= 1'b1;
          if (stag_end) begin
            tmr <= '0;
            if (idx == '0) st <= S_IDLE;
            else           idx <= idx - 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_COOL: begin
          if (pfail_i || !start_i) begin
            st <= S_IDLE;
            if (pfail_i) pfail_o <= 1'b1;
          end else if (tmr == TW'(COOL_CYC-1)) begin
            st  <= S_GAP;
            idx <= '0;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_LATCH: begin
          en_r <= '0;
          if (clr_i) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  for (genvar k = 1; k < N_RAILS; k++) begin : g_ord
    if (!STBY_MASK[k]) begin : g_chk
      en_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(en_o[k]) |-> $past(pg_i[k-1]));
    end
  end

  // R5
  latch_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |-> ((en_o & ~STBY_MASK) == '0));

  // R5
  latch_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latched_o) |-> (fault_retry_o == CNTW'(RETRY_MAX+1)));

  // R9
  pfail_shed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfail_i |=> ((en_o & EARLY_MASK & ~STBY_MASK) == '0));
endmodule

// File: tb/tb_psq_seq.sv
`timescale 1ns/1ps
module tb_psq_seq;
  localparam int N  = 4;
  localparam int S  = 4;
  localparam int T  = 16;
  localparam int C  = 32;
  localparam int RM = 2;
  localparam int Q  = 24;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, pfail_i = 1'b0, clr_i = 1'b0;
  logic [N-1:0] pg_i = '0, ext_fault_i = '0;
  logic [N-1:0] en_o;
  logic up_o, latched_o, pfail_o, fault_valid_o;
  logic [1:0] fault_rail_o, fault_kind_o, fault_retry_o;

  int cyc = 0;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int dly[N], rc[N], rise_c[N], fall_c[N], pgup_c[N];
  bit brk[N];
  logic [N-1:0] en_q = '0;

  psq_seq #(.N_RAILS(N), .STAGGER_CYC(S), .PG_TMO_CYC(T), .COOL_CYC(C),
            .RETRY_MAX(RM), .QUAL_CYC(Q)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pfail_i(pfail_i),
    .clr_i(clr_i), .pg_i(pg_i), .ext_fault_i(ext_fault_i), .en_o(en_o),
    .up_o(up_o), .latched_o(latched_o), .pfail_o(pfail_o),
    .fault_valid_o(fault_valid_o), .fault_rail_o(fault_rail_o),
    .fault_kind_o(fault_kind_o), .fault_retry_o(fault_retry_o));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // rail model: power-good follows enable after dly cycles unless broken
  always @(negedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (en_o[k] && !en_q[k]) rise_c[k] = cyc;
      if (!en_o[k] && en_q[k]) fall_c[k] = cyc;
      if (!en_o[k]) rc[k] = 0;
      else if (rc[k] < 1000) rc[k] = rc[k] + 1;
      if (en_o[k] && rc[k] >= dly[k] && !brk[k]) begin
        if (!pg_i[k]) pgup_c[k] = cyc;
        pg_i[k] = 1'b1;
      end else begin
        pg_i[k] = 1'b0;
      end
    end
    en_q = en_o;
  end

  function automatic bit exp_eq(int a, int b);
    return a == b;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_up(string req);
    int n = 0;
    while (!up_o && n < 3000) begin
      step(1);
      n++;
    end
    chk(up_o, req, up_o, 1);
  endtask

  task automatic check_up_gaps(string req, int c0);
    chk(exp_eq(rise_c[1] - c0, 2*S + 2), req, rise_c[1] - c0, 2*S + 2);
    for (int k = 2; k < N; k++)
      chk(exp_eq(rise_c[k] - pgup_c[k-1], S + 1), req, rise_c[k] - pgup_c[k-1], S + 1);
  endtask

  task automatic power_down_check(string req);
    int c0 = cyc;
    start_i = 1'b0;
    step(3*S + 6);
    chk(exp_eq(fall_c[3] - c0, S + 1), req, fall_c[3] - c0, S + 1);
    chk(exp_eq(fall_c[2] - fall_c[3], S), req, fall_c[2] - fall_c[3], S);
    chk(exp_eq(fall_c[1] - fall_c[2], S), req, fall_c[1] - fall_c[2], S);
    chk(en_o == 4'b0001, "R1", en_o, 1);
  endtask

  initial begin
    int c0;
    int rt_exp;
    void'($urandom(32'd1234));
    for (int k = 0; k < N; k++) begin
      dly[k] = 2; rc[k] = 0; brk[k] = 0;
      rise_c[k] = 0; fall_c[k] = 0; pgup_c[k] = 0;
    end
    step(3);
    // R11 reset state
    chk(en_o == 4'b0001, "R11", en_o, 1);
    chk(!up_o && !latched_o && !pfail_o && !fault_valid_o, "R11",
        {up_o, latched_o, pfail_o, fault_valid_o}, 0);
    rst_ni = 1'b1;
    step(2);
    chk(en_o[0], "R1", en_o[0], 1);

    // R2 directed power-up, R8 power-down
    c0 = cyc;
    start_i = 1'b1;
    wait_up("R2");
    check_up_gaps("R2", c0);
    step(5);
    power_down_check("R8");

    // R2/R8 random pg delays and dwell
    for (int it = 0; it < 6; it++) begin
      for (int k = 0; k < N; k++) dly[k] = 1 + int'($urandom_range(5));
      step(2);
      c0 = cyc;
      start_i = 1'b1;
      wait_up("R2");
      check_up_gaps("R2", c0);
      step(5 + int'($urandom_range(40)));
      power_down_check("R8");
    end
    for (int k = 0; k < N; k++) dly[k] = 2;

    // R3 timeout, R4 cooldown retry
    brk[2] = 1;
    start_i = 1'b1;
    begin
      int n = 0;
      while (!fault_valid_o && n < 500) begin step(1); n++; end
    end
    chk(exp_eq(fall_c[2] - rise_c[2], T), "R3", fall_c[2] - rise_c[2], T);
    chk(fault_kind_o == 2'd1 && fault_rail_o == 2'd2, "R3",
        {fault_kind_o, fault_rail_o}, 6);
    chk(en_o == 4'b0001 && fall_c[1] == fall_c[2], "R4", en_o, 1);
    chk(fault_retry_o == 2'd1, "R4", fault_retry_o, 1);
    brk[2] = 0;
    c0 = fall_c[1];
    wait_up("R4");
    chk(exp_eq(rise_c[1] - c0, C + 2*S + 1), "R4", rise_c[1] - c0, C + 2*S + 1);
    chk(fault_valid_o, "R4", fault_valid_o, 1);

    // R6 external fault on rail 1, R10 no qualification yet
    ext_fault_i[1] = 1'b1;
    step(1);
    ext_fault_i[1] = 1'b0;
    chk(en_o == 4'b0001, "R6", en_o, 1);
    chk(fault_kind_o == 2'd3 && fault_rail_o == 2'd1, "R6",
        {fault_kind_o, fault_rail_o}, 13);
    chk(fault_retry_o == 2'd2, "R10", fault_retry_o, 2);
    wait_up("R4");
    step(Q + 4);
    // R6 pg drop on rail 3 (global), R10 counter requalified
    brk[3] = 1;
    step(2);
    chk(en_o == 4'b0001, "R6", en_o, 1);
    chk(fault_kind_o == 2'd2 && fault_rail_o == 2'd3, "R6",
        {fault_kind_o, fault_rail_o}, 11);
    chk(fault_retry_o == 2'd1, "R10", fault_retry_o, 1);
    brk[3] = 0;
    wait_up("R4");
    clr_i = 1'b1; step(1); clr_i = 1'b0;
    chk(!fault_valid_o, "R4", fault_valid_o, 0);

    // R7 local domain
    step(Q + 4);
    brk[2] = 1;
    step(2);
    chk(en_o == 4'b1011 && up_o, "R7", {up_o, en_o}, 27);
    chk(fault_kind_o == 2'd2 && fault_rail_o == 2'd2, "R7",
        {fault_kind_o, fault_rail_o}, 10);
    step(10);
    chk(en_o == 4'b1011 && up_o, "R7", {up_o, en_o}, 27);
    start_i = 1'b0;
    step(3*S + 6);
    brk[2] = 0;
    chk(en_o == 4'b0001, "R8", en_o, 1);

    // R5 latch after retries
    clr_i = 1'b1; step(1); clr_i = 1'b0;
    brk[2] = 1;
    start_i = 1'b1;
    begin
      int n = 0;
      while (!latched_o && n < 2000) begin step(1); n++; end
    end
    rt_exp = RM + 1;
    chk(latched_o, "R5", latched_o, 1);
    chk(fault_retry_o == 2'(rt_exp) && fault_rail_o == 2'd2, "R5", fault_retry_o, rt_exp);
    step(100);
    chk(latched_o && en_o == 4'b0001, "R5", en_o, 1);
    brk[2] = 0;
    clr_i = 1'b1; step(1); clr_i = 1'b0;
    wait_up("R5");

    // R9 power-fail
    c0 = cyc;
    pfail_i = 1'b1;
    step(1);
    chk(en_o == 4'b0111 && pfail_o, "R9", {pfail_o, en_o}, 23);
    chk(exp_eq(fall_c[3] - c0, 1), "R9", fall_c[3] - c0, 1);
    step(3*S + 4);
    chk(en_o == 4'b0001, "R9", en_o, 1);
    chk(exp_eq(fall_c[2] - c0, 2*S + 1), "R9", fall_c[2] - c0, 2*S + 1);
    chk(exp_eq(fall_c[1] - fall_c[2], S), "R9", fall_c[1] - fall_c[2], S);
    step(50);
    chk(en_o == 4'b0001, "R9", en_o, 1);
    pfail_i = 1'b0;
    clr_i = 1'b1; step(1); clr_i = 1'b0;
    chk(!pfail_o, "R9", pfail_o, 0);
    wait_up("R9");
    power_down_check("R8");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule